// File: doc/BRIEF.md
# Power-Mode Clock Enable Controller

This block sits beside a fast master clock. It turns that clock into clock-enable strobes for the core, the memory and a set of peripherals. All of these domains run at half the master rate, so each enable is a single-cycle pulse on every second master cycle. All strobes share the same phase. A watchdog strobe runs at the same rate and in the same phase, but it is never gated by the power mode or by the peripheral enables.

A three-state machine holds the power mode: Run, Wait or Stop. In Wait the core and memory strobes stop while the peripherals keep running. Any unmasked peripheral interrupt then returns the block to Run. In Stop every core, memory and peripheral strobe is held low, although the divider keeps toggling. Only an external interrupt line or activity on the CAN bus ends Stop without a reset. Both inputs are asynchronous and pass through a two-flop synchronizer first. A wake caused by CAN activity raises a one-cycle flag that tells the CAN peripheral to drop the first frame it receives.

Software can switch off each peripheral strobe on its own through a write port. That register is combined with the mode-level gating. All pins are plain control and status pins. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: `wdog_ce` is low in the first cycle after reset and then alternates every master cycle, whatever the mode. Every other strobe is only ever high in a cycle where `wdog_ce` is high.
- R2: In Run (`pmode` = 0), `core_ce` and `mem_ce` equal `wdog_ce`. Each bit of `per_ce` equals `wdog_ce` ANDed with the matching bit of the peripheral enable register.
- R3: In Run, with `wait_req` high and `stop_req` low at a clock edge, the block enters Wait (`pmode` = 1) at that edge. In Wait, `core_ce` and `mem_ce` stay low and `per_ce` behaves as in Run.
- R4: In Run, with `stop_req` high at a clock edge, the block enters Stop (`pmode` = 2) at that edge. `stop_req` wins over `wait_req`.
- R5: In Wait, if some bit of `irq_req` is high while the matching bit of `irq_mask` is low (mask bit 1 = masked), the block returns to Run at that edge. Masked interrupts, `ext_irq_async` and `can_act_async` leave the block in Wait.
- R6: In Stop, `core_ce`, `mem_ce` and every bit of `per_ce` are low. Interrupt requests, `wait_req` and `stop_req` have no effect in Stop, and `wait_req` and `stop_req` also have no effect in Wait.
- R7: A high level on `ext_irq_async` or `can_act_async` in Stop, set up before clock edge k, puts the block in Run from edge k+2. The block is still in Stop after edge k+1.
- R8: `can_drop_first` is high for exactly the first Run cycle after a Stop exit in which the synchronized CAN activity was high. This holds even when the external interrupt was high at the same time. It stays low for a wake caused only by the external interrupt, and it is low at all other times.
- R9: When `pce_wr` is high, `pce_wdata` is written into the peripheral enable register at the clock edge, in any mode. Bit i gates `per_ce[i]` from the next cycle on.
- R10: Reset places the block in Run, sets every bit of the peripheral enable register, clears the synchronizers, and holds every output strobe and `can_drop_first` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | Core request to enter Wait |
| stop_req | input | 1 | Core request to enter Stop |
| irq_req | input | N_PER | Peripheral interrupt requests |
| irq_mask | input | N_PER | Interrupt mask, 1 = masked |
| ext_irq_async | input | 1 | Asynchronous external interrupt line |
| can_act_async | input | 1 | Asynchronous CAN bus activity |
| pce_wr | input | 1 | Write strobe for the peripheral enable register |
| pce_wdata | input | N_PER | Data for the peripheral enable register |
| core_ce | output | 1 | Core clock enable strobe |
| mem_ce | output | 1 | Memory clock enable strobe |
| per_ce | output | N_PER | Per-peripheral clock enable strobes |
| wdog_ce | output | 1 | Watchdog clock enable strobe |
| pmode | output | 2 | Current mode: 0 Run, 1 Wait, 2 Stop |
| can_drop_first | output | 1 | One-cycle flag: drop the first CAN frame |

## Verification
The assertions take for granted that `wait_req`, `stop_req`, the interrupt vectors and the write port are synchronous to `clk_mst`. They also take for granted that the asynchronous lines, even when they are slow, cause no problem beyond the synchronizer delay. The bench drives every input on the falling edge, so each level is stable across the following rising edge. The random mix keeps mode requests sparse, so that Wait and Stop last long enough for interrupt and wake sources to hit them. Directed cases pin down stop-over-wait priority, masked interrupts and the synchronizer latency.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_WAIT = 2'd1,
    PM_STOP = 2'd2
  } pmode_e;
endpackage

// File: rtl/pcg_sync2.sv
module pcg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d_async[b];
        st2 <= st1;
      end
    end
    assign q_sync[b] = st2;
  end
endmodule

// File: rtl/pcg_half_tick.sv
module pcg_half_tick (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end
endmodule

// File: rtl/pcg_mode_fsm.sv
module pcg_mode_fsm
  import pcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wait_req,
  input  logic   stop_req,
  input  logic   irq_wake,
  input  logic   ext_wake,
  input  logic   can_wake,
  output pmode_e mode,
  output logic   can_drop
);
  pmode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      PM_RUN: begin
        if (stop_req)      mode_nx = PM_STOP;
        else if (wait_req) mode_nx = PM_WAIT;
      end
      PM_WAIT: if (irq_wake) mode_nx = PM_RUN;
      PM_STOP: if (ext_wake || can_wake) mode_nx = PM_RUN;
      default: mode_nx = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= PM_RUN;
      can_drop <= 1'b0;
    end else begin
      mode     <= mode_nx;
      can_drop <= (mode == PM_STOP) && can_wake;
    end
  end
endmodule

// File: rtl/pcg_ce_gen.sv
module pcg_ce_gen
  import pcg_pkg::*;
#(
  parameter int N_PER = 4
) (
  input  logic             tick,
  input  pmode_e           mode,
  input  logic [N_PER-1:0] pce,
  output logic             core_ce,
  output logic             mem_ce,
  output logic [N_PER-1:0] per_ce,
  output logic             wdog_ce
);
  logic sys_on, per_on;

  assign sys_on  = (mode == PM_RUN);
  assign per_on  = (mode != PM_STOP);
  assign core_ce = tick & sys_on;
  assign mem_ce  = tick & sys_on;
  assign wdog_ce = tick;

  for (genvar p = 0; p < N_PER; p++) begin : g_per
    assign per_ce[p] = tick & per_on & pce[p];
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcg_pkg::*;
#(
  parameter int N_PER = 4
) (
  input  logic             clk_mst,
  input  logic             rst_n,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic [N_PER-1:0] irq_req,
  input  logic [N_PER-1:0] irq_mask,
  input  logic             ext_irq_async,
  input  logic             can_act_async,
  input  logic             pce_wr,
  input  logic [N_PER-1:0] pce_wdata,
  output logic             core_ce,
  output logic             mem_ce,
  output logic [N_PER-1:0] per_ce,
  output logic             wdog_ce,
  output logic [1:0]       pmode,
  output logic             can_drop_first
);
  localparam int N_ASYNC = 2;

  logic               tick;
  logic [N_ASYNC-1:0] wake_s;
  logic [N_PER-1:0]   pce_q;
  logic               irq_any;
  pmode_e             mode;

  pcg_half_tick u_tick (.clk(clk_mst), .rst_n(rst_n), .tick(tick));

  pcg_sync2 #(.W(N_ASYNC)) u_sync (
    .clk(clk_mst), .rst_n(rst_n),
    .d_async({can_act_async, ext_irq_async}),
    .q_sync(wake_s)
  );

  always_ff @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n)      pce_q <= '1;
    else if (pce_wr) pce_q <= pce_wdata;
  end

  assign irq_any = |(irq_req & ~irq_mask);

  pcg_mode_fsm u_fsm (
    .clk(clk_mst), .rst_n(rst_n),
    .wait_req(wait_req), .stop_req(stop_req),
    .irq_wake(irq_any), .ext_wake(wake_s[0]), .can_wake(wake_s[1]),
    .mode(mode), .can_drop(can_drop_first)
  );

  pcg_ce_gen #(.N_PER(N_PER)) u_ce (
    .tick(tick), .mode(mode), .pce(pce_q),
    .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce), .wdog_ce(wdog_ce)
  );

  assign pmode = mode;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
  parameter int N_PER = 4
) (
  input logic             clk_mst,
  input logic             rst_n,
  input logic [N_PER-1:0] irq_req,
  input logic [N_PER-1:0] irq_mask,
  input logic             core_ce,
  input logic             mem_ce,
  input logic [N_PER-1:0] per_ce,
  input logic             wdog_ce,
  input logic [1:0]       pmode,
  input logic             can_drop_first,
  input logic [N_PER-1:0] pce_q
);
  assert_wdog_alt_R1: assert property (@(posedge clk_mst) disable iff (!rst_n)
    wdog_ce |=> !wdog_ce);
  assert_wdog_back_R1: assert property (@(posedge clk_mst) disable iff (!rst_n)
    !wdog_ce |=> wdog_ce);
  assert_phase_R1: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (core_ce || mem_ce || (|per_ce)) |-> wdog_ce);
  assert_run_core_R2: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (pmode == 2'd0) |-> (core_ce == wdog_ce) && (mem_ce == wdog_ce));
  assert_wait_off_R3: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (pmode == 2'd1) |-> !core_ce && !mem_ce);
  assert_stop_off_R6: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (pmode == 2'd2) |-> !core_ce && !mem_ce && (per_ce == '0));
  assert_mode_legal_R4: assert property (@(posedge clk_mst) disable iff (!rst_n)
    pmode != 2'd3);
  assert_wait_exit_R5: assert property (@(posedge clk_mst) disable iff (!rst_n)
    ($past(pmode) == 2'd1 && pmode == 2'd0) |-> $past(|(irq_req & ~irq_mask)));
  assert_stop_exit_R7: assert property (@(posedge clk_mst) disable iff (!rst_n)
    ($past(pmode) == 2'd2 && pmode != 2'd2) |-> pmode == 2'd0);
  assert_drop_R8: assert property (@(posedge clk_mst) disable iff (!rst_n)
    can_drop_first |-> (pmode == 2'd0) && ($past(pmode) == 2'd2));
  assert_pce_gate_R9: assert property (@(posedge clk_mst) disable iff (!rst_n)
    (per_ce & ~pce_q) == '0);
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.N_PER(N_PER)) u_chk (
  .clk_mst(clk_mst), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
  .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce), .wdog_ce(wdog_ce),
  .pmode(pmode), .can_drop_first(can_drop_first), .pce_q(pce_q)
);

// File: tb/pwr_clk_ctrl_tb_top.sv
module pwr_clk_ctrl_tb_top;
  localparam int NP = 4;

  logic clk_mst = 1'b0;
  logic rst_n;
  logic wait_req, stop_req, ext_irq_async, can_act_async, pce_wr;
  logic [NP-1:0] irq_req, irq_mask, pce_wdata;
  logic core_ce, mem_ce, wdog_ce, can_drop_first;
  logic [NP-1:0] per_ce;
  logic [1:0] pmode;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_mst = ~clk_mst;

  pwr_clk_ctrl #(.N_PER(NP)) dut_i (
    .clk_mst(clk_mst), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .irq_req(irq_req), .irq_mask(irq_mask), .ext_irq_async(ext_irq_async),
    .can_act_async(can_act_async), .pce_wr(pce_wr), .pce_wdata(pce_wdata),
    .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce), .wdog_ce(wdog_ce),
    .pmode(pmode), .can_drop_first(can_drop_first)
  );

  // expected-state model built from the requirements
  logic          m_tick, m_drop;
  logic [1:0]    m_mode;
  logic [1:0]    m_s1, m_s2;   // bit0 ext, bit1 can
  logic [NP-1:0] m_pce;

  function automatic logic [1:0] next_mode(logic [1:0] md, logic wr, logic sr,
                                           logic [NP-1:0] rq, logic [NP-1:0] mk,
                                           logic [1:0] s2);
    case (md)
      2'd0: return sr ? 2'd2 : (wr ? 2'd1 : 2'd0);
      2'd1: return (|(rq & ~mk)) ? 2'd0 : 2'd1;
      default: return (|s2) ? 2'd0 : 2'd2;
    endcase
  endfunction

  always @(posedge clk_mst or negedge rst_n) begin
    if (!rst_n) begin
      m_tick <= 1'b0; m_drop <= 1'b0; m_mode <= 2'd0;
      m_s1 <= '0; m_s2 <= '0; m_pce <= '1;
    end else begin
      m_tick <= ~m_tick;
      m_drop <= (m_mode == 2'd2) && m_s2[1];
      m_mode <= next_mode(m_mode, wait_req, stop_req, irq_req, irq_mask, m_s2);
      m_s1   <= {can_act_async, ext_irq_async};
      m_s2   <= m_s1;
      if (pce_wr) m_pce <= pce_wdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic sys_exp;
    sys_exp = m_tick && (m_mode == 2'd0);
    chk("R1 wdog_ce", 32'(wdog_ce), 32'(m_tick));
    chk(m_mode == 2'd0 ? "R2 core_ce" : (m_mode == 2'd1 ? "R3 core_ce" : "R6 core_ce"),
        32'(core_ce), 32'(sys_exp));
    chk("R2 mem_ce", 32'(mem_ce), 32'(sys_exp));
    chk(m_mode == 2'd2 ? "R6 per_ce" : "R9 per_ce", 32'(per_ce),
        32'((m_tick && m_mode != 2'd2) ? m_pce : '0));
    chk("R5 pmode", 32'(pmode), 32'(m_mode));
    chk("R8 can_drop_first", 32'(can_drop_first), 32'(m_drop));
  endtask

  task automatic step();
    @(posedge clk_mst);
    @(negedge clk_mst);
    check_all();
  endtask

  task automatic idle_inputs();
    wait_req = 0; stop_req = 0; irq_req = '0; irq_mask = '0;
    ext_irq_async = 0; can_act_async = 0; pce_wr = 0; pce_wdata = '0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk_mst);
    rst_n = 1;
    // R10: reset state
    chk("R10 pmode", 32'(pmode), 32'd0);
    chk("R10 strobes", 32'({core_ce, mem_ce, per_ce, wdog_ce, can_drop_first}), 32'd0);
    step();
    chk("R10 pce all ones", 32'(per_ce), 32'({NP{1'b1}}));

    // R4: stop wins over wait
    wait_req = 1; stop_req = 1;
    step();
    chk("R4 stop priority", 32'(pmode), 32'd2);

    // R6: requests and irqs ignored in Stop
    irq_req = '1; stop_req = 0;
    repeat (4) step();
    chk("R6 stays stop", 32'(pmode), 32'd2);
    idle_inputs();

    // R7/R8: CAN wake latency and drop flag
    can_act_async = 1;
    step(); step();
    chk("R7 still stop after k+1", 32'(pmode), 32'd2);
    step();
    chk("R7 run at k+2", 32'(pmode), 32'd0);
    chk("R8 drop flag high", 32'(can_drop_first), 32'd1);
    can_act_async = 0;
    step();
    chk("R8 drop flag one cycle", 32'(can_drop_first), 32'd0);

    // R7/R8: ext wake gives no drop flag
    stop_req = 1; step(); stop_req = 0;
    ext_irq_async = 1; step(); step(); step();
    chk("R7 ext wake", 32'(pmode), 32'd0);
    chk("R8 no drop on ext", 32'(can_drop_first), 32'd0);
    ext_irq_async = 0;

    // R3/R5: Wait entry, masked irq and async lines ignored, unmasked exit
    wait_req = 1; step(); wait_req = 0;
    chk("R3 wait entered", 32'(pmode), 32'd1);
    irq_req = 4'b0010; irq_mask = 4'b0010; ext_irq_async = 1; can_act_async = 1;
    repeat (4) step();
    chk("R5 masked stays wait", 32'(pmode), 32'd1);
    // R9: write in Wait
    pce_wr = 1; pce_wdata = 4'b0101; step(); pce_wr = 0;
    if (!wdog_ce) step();
    chk("R9 per_ce pattern", 32'(per_ce), 32'h5);
    irq_mask = 4'b0000; step();
    chk("R5 unmasked exit", 32'(pmode), 32'd0);
    idle_inputs();
    repeat (3) step();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      wait_req      = ($urandom % 8) == 0;
      stop_req      = ($urandom % 12) == 0;
      irq_req       = (($urandom % 6) == 0) ? NP'($urandom) : '0;
      irq_mask      = NP'($urandom);
      ext_irq_async = ($urandom % 20) == 0;
      can_act_async = ($urandom % 20) == 0;
      pce_wr        = ($urandom % 10) == 0;
      pce_wdata     = NP'($urandom);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule